// File: doc/BRIEF.md
# Per-Source Interrupt Source Controller

This block is the source layer of a two-level interrupt scheme. It watches `NUM_SRC` interrupt lines. Each line is declared once as either an edge (message-style) source or a level source. For each source the block holds a target server number and an 8-bit priority, where the value 0xFF means the source is masked. It also holds a small set of status flags that record events which could not be delivered yet. When a source becomes deliverable, the block queues it. Queued sources are handed to the presentation layer one at a time on a valid/ready offer port. Each offer carries the global source number (local index plus the parameter `BASE_NUM`), the priority and the server.

The presentation layer sends three kinds of request back. A reject pulse means an offer was turned away. An end-of-interrupt (EOI) pulse means the handler has finished. A resend pulse asks every source to look again at what it still owes. Edge sources keep a flag for an event that arrived while masked and a flag for an event that was rejected. Both flags are replayed later. Level sources follow the line with an asserted flag and use a sent flag, so they are not presented twice before an EOI or a reject.

Top module: `irq_source_ctrl`

## Requirements
- R1: While reset is held, and in the first cycle after it, `offer_valid` is 0. Reset sets every priority to 0xFF (masked) and clears every status flag. Reset does not change any source type.
- R2: A rising edge on the line of an unmasked edge source queues one offer. The offer has `offer_num` = `BASE_NUM` + index and carries the configured priority and server. Holding the line high produces no further offer.
- R3: A rising edge on a masked edge source produces no offer and is remembered. A configuration write with priority 0xFF keeps it remembered. A configuration write with any other priority releases exactly one offer.
- R4: A level source is offered when three conditions hold: its priority is not 0xFF, its line is high, and it has not already been sent. The offer marks it sent. A later resend does not offer it again while it is still marked sent.
- R5: A reject of an edge source marks it rejected. The next resend clears that mark and offers it once. A resend with no prior reject offers nothing.
- R6: A reject of a level source clears its sent flag. A following resend offers it again only if its line is still high.
- R7: An EOI of a level source clears its sent flag, so a following resend offers it again while its line is high. An EOI of an edge source has no effect.
- R8: A source type can be set only while it is still untyped (`type_level` = 1 selects level, 0 selects edge). Any later type write to that source is ignored.
- R9: A reject or EOI is ignored when its number is below `BASE_NUM` or at or above `BASE_NUM` + `NUM_SRC`.
- R10: When several sources are queued, they are offered in ascending index order, with one offer outstanding at a time. Number, priority and server hold steady while `offer_valid` is high and `offer_ready` is low.
- R11: An untyped source ignores its line and is never offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_in | input | NUM_SRC | Interrupt lines, one per source |
| type_we | input | 1 | Type write strobe |
| type_idx | input | IDX_W | Source index for the type write |
| type_level | input | 1 | 1 = level source, 0 = edge source |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | IDX_W | Source index for the configuration write |
| cfg_server | input | SRV_W | New target server |
| cfg_prio | input | 8 | New priority (0xFF masks) |
| rej_valid | input | 1 | Reject pulse |
| rej_num | input | NUM_W | Global number being rejected |
| eoi_valid | input | 1 | EOI pulse |
| eoi_num | input | NUM_W | Global number being completed |
| resend | input | 1 | Resend pulse; every source is re-examined |
| offer_valid | output | 1 | An offer is presented |
| offer_ready | input | 1 | The presentation layer takes the offer |
| offer_num | output | NUM_W | Global source number of the offer |
| offer_prio | output | 8 | Priority of the offer |
| offer_server | output | SRV_W | Target server of the offer |

## Verification
The assertions assume three things about the environment. First, `offer_ready` is only meaningful while `offer_valid` is high. Second, a reject or EOI refers to a source that was actually offered. Third, no source receives a reject, an EOI, a configuration write and a line edge in the same cycle. The stimulus respects all three. Every strobe is a single-cycle pulse driven between clock edges. Reject and EOI are issued only after the matching offer has been accepted. Random rounds change priorities only on edge sources, and only while nothing is queued, before firing a random set of lines at once.

// File: rtl/irqsrc_pkg.sv
package irqsrc_pkg;

    localparam int PRIO_W = 8;
    localparam logic [PRIO_W-1:0] PRIO_MASKED = '1;

    typedef enum logic [1:0] {
        KIND_NONE  = 2'd0,
        KIND_EDGE  = 2'd1,
        KIND_LEVEL = 2'd2
    } src_kind_e;

    typedef struct packed {
        logic held;      // edge event seen while masked
        logic bounced;   // edge offer turned away
        logic high;      // level line state
        logic sent;      // level offer outstanding
        logic queued;    // waiting for the offer port
    } src_flags_t;

    function automatic logic prio_open(input logic [PRIO_W-1:0] p);
        return p != PRIO_MASKED;
    endfunction

endpackage

// File: rtl/irqsrc_slot.sv
module irqsrc_slot
    import irqsrc_pkg::*;
#(
    parameter int SRV_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              type_set,
    input  logic              type_level,
    input  logic              line,
    input  logic              rej_hit,
    input  logic              eoi_hit,
    input  logic              resend,
    input  logic              cfg_hit,
    input  logic [SRV_W-1:0]  cfg_server,
    input  logic [PRIO_W-1:0] cfg_prio,
    input  logic              take,
    output logic              queued,
    output logic [PRIO_W-1:0] prio,
    output logic [SRV_W-1:0]  server
);

    src_kind_e  kind = KIND_NONE;
    src_flags_t flg, nf;
    logic [PRIO_W-1:0] n_prio;
    logic [SRV_W-1:0]  n_srv;
    logic line_q;
    logic eval;

    always_ff @(posedge clk) begin
        if (type_set && kind == KIND_NONE)
            kind <= type_level ? KIND_LEVEL : KIND_EDGE;
    end

    always_comb begin
        nf     = flg;
        n_prio = prio;
        n_srv  = server;
        eval   = 1'b0;
        if (take)
            nf.queued = 1'b0;
        case (kind)
            KIND_EDGE: begin
                if (rej_hit)
                    nf.bounced = 1'b1;
                if (line && !line_q) begin
                    if (prio_open(prio)) nf.queued = 1'b1;
                    else                 nf.held   = 1'b1;
                end
            end
            KIND_LEVEL: begin
                if (rej_hit || eoi_hit)
                    nf.sent = 1'b0;
                if (line != flg.high)
                    eval = 1'b1;
                nf.high = line;
            end
            default: ;
        endcase
        if (cfg_hit) begin
            n_prio = cfg_prio;
            n_srv  = cfg_server;
            if (kind == KIND_EDGE && nf.held && prio_open(cfg_prio)) begin
                nf.held   = 1'b0;
                nf.queued = 1'b1;
            end
            if (kind == KIND_LEVEL)
                eval = 1'b1;
        end
        if (resend) begin
            if (kind == KIND_EDGE && nf.bounced) begin
                nf.bounced = 1'b0;
                if (prio_open(n_prio))
                    nf.queued = 1'b1;
            end
            if (kind == KIND_LEVEL)
                eval = 1'b1;
        end
        if (kind == KIND_LEVEL && eval && prio_open(n_prio) && nf.high && !nf.sent) begin
            nf.sent   = 1'b1;
            nf.queued = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flg    <= '0;
            prio   <= PRIO_MASKED;
            server <= '0;
            line_q <= 1'b0;
        end else begin
            flg    <= nf;
            prio   <= n_prio;
            server <= n_srv;
            line_q <= line;
        end
    end

    assign queued = flg.queued;

endmodule

// File: rtl/irqsrc_pick.sv
module irqsrc_pick #(
    parameter int N = 8,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req,
    output logic [N-1:0]     gnt,
    output logic [IDX_W-1:0] idx,
    output logic             any
);

    always_comb begin
        gnt = '0;
        idx = '0;
        any = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                gnt = '0;
                gnt[i] = 1'b1;
                idx = IDX_W'(i);
                any = 1'b1;
            end
        end
    end

endmodule

// File: rtl/irqsrc_match.sv
module irqsrc_match #(
    parameter int N = 8,
    parameter int NUM_W = 16,
    parameter logic [NUM_W-1:0] BASE_NUM = 'h1000
) (
    input  logic             valid,
    input  logic [NUM_W-1:0] num,
    output logic [N-1:0]     hit
);

    logic [NUM_W-1:0] rel;
    logic             in_range;

    assign rel      = num - BASE_NUM;
    assign in_range = valid && (num >= BASE_NUM) && (rel < NUM_W'(N));

    for (genvar i = 0; i < N; i++) begin : g_hit
        assign hit[i] = in_range && (rel == NUM_W'(i));
    end

endmodule

// File: rtl/irq_source_ctrl.sv
module irq_source_ctrl
    import irqsrc_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int SRV_W = 4,
    parameter int NUM_W = 16,
    parameter logic [NUM_W-1:0] BASE_NUM = 'h1000,
    localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] line_in,
    input  logic               type_we,
    input  logic [IDX_W-1:0]   type_idx,
    input  logic               type_level,
    input  logic               cfg_we,
    input  logic [IDX_W-1:0]   cfg_idx,
    input  logic [SRV_W-1:0]   cfg_server,
    input  logic [PRIO_W-1:0]  cfg_prio,
    input  logic               rej_valid,
    input  logic [NUM_W-1:0]   rej_num,
    input  logic               eoi_valid,
    input  logic [NUM_W-1:0]   eoi_num,
    input  logic               resend,
    output logic               offer_valid,
    input  logic               offer_ready,
    output logic [NUM_W-1:0]   offer_num,
    output logic [PRIO_W-1:0]  offer_prio,
    output logic [SRV_W-1:0]   offer_server
);

    logic [NUM_SRC-1:0] rej_hit, eoi_hit, pend_vec, take_vec, gnt;
    logic [PRIO_W-1:0]  slot_prio [NUM_SRC];
    logic [SRV_W-1:0]   slot_srv  [NUM_SRC];
    logic [IDX_W-1:0]   pick_idx, off_idx;
    logic               pick_any, load;

    irqsrc_match #(.N(NUM_SRC), .NUM_W(NUM_W), .BASE_NUM(BASE_NUM)) u_rej (
        .valid(rej_valid), .num(rej_num), .hit(rej_hit));
    irqsrc_match #(.N(NUM_SRC), .NUM_W(NUM_W), .BASE_NUM(BASE_NUM)) u_eoi (
        .valid(eoi_valid), .num(eoi_num), .hit(eoi_hit));

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_slot
        irqsrc_slot #(.SRV_W(SRV_W)) u_slot (
            .clk        (clk),
            .rst        (rst),
            .type_set   (type_we && type_idx == IDX_W'(i)),
            .type_level (type_level),
            .line       (line_in[i]),
            .rej_hit    (rej_hit[i]),
            .eoi_hit    (eoi_hit[i]),
            .resend     (resend),
            .cfg_hit    (cfg_we && cfg_idx == IDX_W'(i)),
            .cfg_server (cfg_server),
            .cfg_prio   (cfg_prio),
            .take       (take_vec[i]),
            .queued     (pend_vec[i]),
            .prio       (slot_prio[i]),
            .server     (slot_srv[i])
        );
    end

    irqsrc_pick #(.N(NUM_SRC)) u_pick (
        .req(pend_vec), .gnt(gnt), .idx(pick_idx), .any(pick_any));

    assign load     = !offer_valid || offer_ready;
    assign take_vec = load ? gnt : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            offer_valid  <= 1'b0;
            off_idx      <= '0;
            offer_prio   <= PRIO_MASKED;
            offer_server <= '0;
        end else if (load) begin
            offer_valid <= pick_any;
            if (pick_any) begin
                off_idx      <= pick_idx;
                offer_prio   <= slot_prio[pick_idx];
                offer_server <= slot_srv[pick_idx];
            end
        end
    end

    assign offer_num = BASE_NUM + NUM_W'(off_idx);

endmodule

// File: rtl/irqsrc_checker.sv
module irqsrc_checker #(
    parameter int NUM_SRC = 8,
    parameter int SRV_W = 4,
    parameter int NUM_W = 16,
    parameter logic [NUM_W-1:0] BASE_NUM = 'h1000
) (
    input logic               clk,
    input logic               rst,
    input logic               offer_valid,
    input logic               offer_ready,
    input logic [NUM_W-1:0]   offer_num,
    input logic [7:0]         offer_prio,
    input logic [SRV_W-1:0]   offer_server,
    input logic [NUM_SRC-1:0] pend_vec
);

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> !offer_valid);

    assert_offer_hold_R10: assert property (@(posedge clk) disable iff (rst)
        offer_valid && !offer_ready |=> offer_valid && $stable(offer_num)
            && $stable(offer_prio) && $stable(offer_server));

    assert_offer_range_R9: assert property (@(posedge clk) disable iff (rst)
        offer_valid |-> (offer_num >= BASE_NUM) && ((offer_num - BASE_NUM) < NUM_W'(NUM_SRC)));

    assert_offer_needs_queue_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(offer_valid) |-> $past(|pend_vec));

endmodule

bind irq_source_ctrl irqsrc_checker #(
    .NUM_SRC(NUM_SRC), .SRV_W(SRV_W), .NUM_W(NUM_W), .BASE_NUM(BASE_NUM)
) u_chk (
    .clk(clk), .rst(rst), .offer_valid(offer_valid), .offer_ready(offer_ready),
    .offer_num(offer_num), .offer_prio(offer_prio), .offer_server(offer_server),
    .pend_vec(pend_vec)
);

// File: tb/irq_source_ctrl_test.sv
module irq_source_ctrl_test;

    localparam int N = 8;
    localparam int SRV_W = 4;
    localparam int NUM_W = 16;
    localparam logic [NUM_W-1:0] BASE = 16'h1000;
    localparam int IDX_W = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [N-1:0] line_in = '0;
    logic type_we = 0, type_level = 0, cfg_we = 0, rej_valid = 0, eoi_valid = 0;
    logic resend = 0, offer_ready = 0;
    logic [IDX_W-1:0] type_idx = '0, cfg_idx = '0;
    logic [SRV_W-1:0] cfg_server = '0;
    logic [7:0] cfg_prio = '0;
    logic [NUM_W-1:0] rej_num = '0, eoi_num = '0;
    logic offer_valid;
    logic [NUM_W-1:0] offer_num;
    logic [7:0] offer_prio;
    logic [SRV_W-1:0] offer_server;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    irq_source_ctrl #(.NUM_SRC(N), .SRV_W(SRV_W), .NUM_W(NUM_W), .BASE_NUM(BASE)) uut (
        .clk(clk), .rst(rst), .line_in(line_in),
        .type_we(type_we), .type_idx(type_idx), .type_level(type_level),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_server(cfg_server), .cfg_prio(cfg_prio),
        .rej_valid(rej_valid), .rej_num(rej_num), .eoi_valid(eoi_valid), .eoi_num(eoi_num),
        .resend(resend), .offer_valid(offer_valid), .offer_ready(offer_ready),
        .offer_num(offer_num), .offer_prio(offer_prio), .offer_server(offer_server));

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [NUM_W-1:0] gnum(input int idx);
        return BASE + NUM_W'(idx);
    endfunction

    task automatic set_type(input int idx, input bit lvl);
        type_we = 1; type_idx = IDX_W'(idx); type_level = lvl; tick(); type_we = 0;
    endtask

    task automatic cfg(input int idx, input int prio, input int srv);
        cfg_we = 1; cfg_idx = IDX_W'(idx); cfg_prio = 8'(prio); cfg_server = SRV_W'(srv);
        tick(); cfg_we = 0;
    endtask

    task automatic pulse(input logic [N-1:0] m);
        line_in = line_in | m; tick(); line_in = line_in & ~m;
    endtask

    task automatic do_reject(input logic [NUM_W-1:0] num);
        rej_valid = 1; rej_num = num; tick(); rej_valid = 0;
    endtask

    task automatic do_eoi(input logic [NUM_W-1:0] num);
        eoi_valid = 1; eoi_num = num; tick(); eoi_valid = 0;
    endtask

    task automatic do_resend();
        resend = 1; tick(); resend = 0;
    endtask

    task automatic expect_offer(input int idx, input int prio, input int srv, input int hold, input string req);
        int w = 0;
        logic [NUM_W-1:0] n0;
        while (!offer_valid && w < 12) begin tick(); w++; end
        check(offer_valid, req, offer_valid, 1);
        check(offer_num == gnum(idx), req, offer_num, gnum(idx));
        check(offer_prio == 8'(prio), req, offer_prio, prio);
        check(offer_server == SRV_W'(srv), req, offer_server, srv);
        n0 = offer_num;
        for (int h = 0; h < hold; h++) tick();
        if (hold > 0)
            check(offer_valid && offer_num == n0, "R10 hold", offer_num, n0);
        offer_ready = 1; tick(); offer_ready = 0;
    endtask

    task automatic expect_none(input int cycles, input string req);
        bit seen = 0;
        logic [NUM_W-1:0] n = '0;
        for (int c = 0; c < cycles; c++) begin
            if (offer_valid) begin seen = 1; n = offer_num; end
            tick();
        end
        if (offer_valid) begin seen = 1; n = offer_num; end
        check(!seen, req, n, 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        logic [N-1:0] m;
        int rp [4];
        void'($urandom(32'h5eed));
        tick(); tick();
        // types: 0..3 edge, 4..6 level, 7 untyped
        for (int i = 0; i < 4; i++) set_type(i, 0);
        for (int i = 4; i < 7; i++) set_type(i, 1);
        check(offer_valid == 0, "R1 in reset", offer_valid, 0);
        rst = 0;
        check(offer_valid == 0, "R1 after reset", offer_valid, 0);

        // R1/R3: masked edge event is remembered
        pulse(8'h01);
        expect_none(4, "R1 masked after reset");
        cfg(0, 5, 1);
        expect_offer(0, 5, 1, 0, "R3 release on unmask");
        expect_none(3, "R3 single release");
        pulse(8'h02);
        cfg(1, 8'hFF, 2);
        expect_none(4, "R3 stays held");
        cfg(1, 3, 2);
        expect_offer(1, 3, 2, 0, "R3 release src1");

        // R2
        cfg(2, 7, 9);
        line_in[2] = 1; tick();
        expect_offer(2, 7, 9, 0, "R2 edge offer");
        expect_none(4, "R2 held line no repeat");
        line_in[2] = 0; tick();

        // R5
        do_reject(gnum(2));
        expect_none(3, "R5 reject no offer");
        do_resend();
        expect_offer(2, 7, 9, 0, "R5 resend re-offer");
        do_resend();
        expect_none(4, "R5 resend without reject");

        // R4
        cfg(4, 4, 1);
        line_in[4] = 1; tick();
        expect_offer(4, 4, 1, 0, "R4 level offer");
        do_resend();
        expect_none(4, "R4 sent blocks resend");

        // R7
        do_eoi(gnum(4));
        expect_none(3, "R7 eoi alone");
        do_resend();
        expect_offer(4, 4, 1, 0, "R7 eoi then resend");
        do_eoi(gnum(2));
        do_resend();
        expect_none(4, "R7 eoi on edge ignored");

        // R6
        do_reject(gnum(4));
        do_resend();
        expect_offer(4, 4, 1, 0, "R6 reject level re-offer");
        line_in[4] = 0; tick();
        do_reject(gnum(4));
        do_resend();
        expect_none(4, "R6 low line no re-offer");

        // R9
        cfg(5, 2, 3);
        line_in[5] = 1; tick();
        expect_offer(5, 2, 3, 0, "R9 setup");
        do_eoi(gnum(8));
        do_reject(BASE - 16'd3);
        do_resend();
        expect_none(4, "R9 out of range ignored");
        do_eoi(gnum(5));
        do_resend();
        expect_offer(5, 2, 3, 0, "R9 in range eoi");
        line_in[5] = 0; tick();

        // R11
        pulse(8'h80);
        cfg(7, 1, 1);
        line_in[7] = 1; tick();
        do_resend();
        expect_none(4, "R11 untyped ignored");
        line_in[7] = 0; tick();

        // R10 ordering with stall
        cfg(3, 6, 4);
        pulse(8'h0F);
        expect_offer(0, 5, 1, 3, "R10 order 0");
        expect_offer(1, 3, 2, 0, "R10 order 1");
        expect_offer(2, 7, 9, 2, "R10 order 2");
        expect_offer(3, 6, 4, 0, "R10 order 3");
        expect_none(3, "R10 drained");

        // random rounds on edge sources (R2, R10)
        for (int it = 0; it < 15; it++) begin
            for (int s = 0; s < 4; s++) begin
                rp[s] = $urandom_range(0, 254);
                cfg(s, rp[s], s + it);
            end
            m = N'($urandom_range(1, 15));
            pulse(m);
            for (int s = 0; s < 4; s++)
                if (m[s]) expect_offer(s, rp[s], (s + it) % 16, $urandom_range(0, 3), "R2 random");
            expect_none(2, "R10 random drained");
        end

        // R8 and R1: types survive reset, second type write ignored
        rst = 1; tick(); tick();
        check(offer_valid == 0, "R1 reset again", offer_valid, 0);
        rst = 0;
        pulse(8'h04);
        expect_none(4, "R1 priority masked after reset");
        set_type(0, 1);
        cfg(0, 9, 5);
        line_in[0] = 1; tick();
        expect_offer(0, 9, 5, 0, "R8 still edge");
        do_eoi(gnum(0));
        do_resend();
        expect_none(4, "R8 no level re-offer");
        line_in[0] = 0; tick();

        finish_run();
    end

endmodule